// File: doc/BRIEF.md
# Register Restore and Default Controller

This block holds a byte-wide register file split into two kinds of storage. Brightness and configuration registers have a copy in a non-volatile image. Control and status-flag registers have no such copy. The block decides how each kind is restored after any of several events. A walker copies the image into every image-backed register, one address per clock, through a shadow-image read port. Control and flag registers are set to fixed factory values or left as they are, depending on the event.

Events come from two places. The hardware sources are an asynchronous power-on reset, the rising edge of an undervoltage lockout input, and the rising edge of an enable input. The software sources are self-clearing command bits in the command register at 90h. Hardware sources take priority over commands. A command that sets a persistent mode raises a level output: fail-safe or program mode.

Top module: `regdef_ctrl`

## Requirements
- R1: Image-backed addresses are 00h–17h, 20h–37h, 40h–44h, 50h–67h and 70h–87h, 101 registers in all. Power-on reset starts a walk that writes one of them per clock from `eep_data` at `eep_addr`. `busy` reads 1 straight after reset. `load_done` is high for exactly one cycle, 101 clocks after the walk starts, and `busy` drops in that same cycle.
- R2: After power-on reset, control registers 90h–98h read 00h. Flag register A0h reads 01h and flags A1h–AFh read 00h. `failsafe` and `prog_mode` are 0.
- R3: Writing bit 1 of 90h (reload) reloads every image-backed register and leaves control and flag registers unchanged.
- R4: Writing bit 0 of 90h (defaults) reloads every image-backed register, returns 91h–98h to 00h and leaves the flags unchanged. The walk takes 101 clocks.
- R5: Writing bit 2 of 90h sets `failsafe` to 1 from the next cycle. It also reloads the image-backed registers and leaves control and flag registers unchanged.
- R6: Writing bit 3 of 90h sets `prog_mode` to 1 from the next cycle. It also reloads the image-backed registers and leaves control and flag registers unchanged.
- R7: Writing bit 4 of 90h (soft reset) clears only register 93h. It starts no walk.
- R8: Command bits read back at 90h as written while their action is pending. They read 0 from the cycle `load_done` is high. A soft-reset-only command reads 0 one cycle after it is written.
- R9: A rising edge on `uvlo` or `en` sets 90h–98h and A1h–AFh to 00h, clears `failsafe` and `prog_mode`, and restarts the walk. Register A0h becomes 02h after `uvlo` and 04h after `en`. When both rise together, A0h becomes 02h. A falling edge does nothing.
- R10: A bus write in the same cycle as a hardware restart is dropped. This includes a command write.
- R11: A command write while `busy` is high is ignored.
- R12: Image-backed registers, 91h–98h and A0h–AFh are writable from the bus. Writes to any other address are ignored, and those addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| uvlo | input | 1 | Undervoltage lockout; rising edge restarts |
| en | input | 1 | Enable; rising edge restarts |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW (8) | Bus write address |
| wr_data | input | DW (8) | Bus write data |
| rd_addr | input | AW (8) | Bus read address |
| rd_data | output | DW (8) | Read data (combinational by default) |
| eep_addr | output | AW (8) | Shadow image address being walked |
| eep_data | input | DW (8) | Shadow image data for `eep_addr` |
| busy | output | 1 | Walk in progress |
| load_done | output | 1 | One-cycle pulse when a walk finishes |
| failsafe | output | 1 | Fail-safe mode latched |
| prog_mode | output | 1 | Image program mode latched |

## Verification
A walker index that skips or repeats an address leaves at least one image-backed register with a stale image value. A wrong span table does the same. A sweep of all 256 read addresses finds this as soon as `load_done` pulses, and it also catches a miscounted walk length. A wrong restore action for a register group shows up in the sweep right after that event. Examples are a restart that spares a flag or a command that touches control registers. A command register that fails to clear or drops a hold is visible at 90h within one cycle of the write or of `load_done`.

// File: rtl/regdef_pkg.sv
package regdef_pkg;

   localparam int NUM_SPANS = 5;
   localparam int SPAN_BASE [NUM_SPANS] = '{'h00, 'h20, 'h40, 'h50, 'h70};
   localparam int SPAN_LEN  [NUM_SPANS] = '{24, 24, 5, 24, 24};

   localparam int CMD_ADDR   = 'h90;
   localparam int CTRL_HI    = 'h98;
   localparam int SOFT_ADDR  = 'h93;
   localparam int FLAG_LO    = 'hA0;
   localparam int FLAG_HI    = 'hAF;
   localparam int CAUSE_ADDR = 'hA0;

   localparam int CMD_W       = 5;
   localparam int CMD_DEFAULT = 0;
   localparam int CMD_RELOAD  = 1;
   localparam int CMD_SAFE    = 2;
   localparam int CMD_PROG    = 3;
   localparam int CMD_SOFT    = 4;

   localparam logic [7:0] CODE_POR  = 8'h01;
   localparam logic [7:0] CODE_UVLO = 8'h02;
   localparam logic [7:0] CODE_EN   = 8'h04;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_UVLO = 2'd1,
      CAUSE_EN   = 2'd2
   } restart_cause_e;

   function automatic int backed_total();
      int sum = 0;
      for (int s = 0; s < NUM_SPANS; s++) sum += SPAN_LEN[s];
      return sum;
   endfunction

   localparam int BACKED_N = backed_total();

   // Map a walk index onto the address it restores.
   function automatic int span_addr(int idx);
      int rem = idx;
      int res = 0;
      bit hit = 1'b0;
      for (int s = 0; s < NUM_SPANS; s++) begin
         if (!hit && rem < SPAN_LEN[s]) begin
            res = SPAN_BASE[s] + rem;
            hit = 1'b1;
         end else if (!hit) begin
            rem -= SPAN_LEN[s];
         end
      end
      return res;
   endfunction

   function automatic bit in_backed(int a);
      bit r = 1'b0;
      for (int s = 0; s < NUM_SPANS; s++)
         if (a >= SPAN_BASE[s] && a < SPAN_BASE[s] + SPAN_LEN[s]) r = 1'b1;
      return r;
   endfunction

   function automatic bit in_ctrl(int a);
      return a >= CMD_ADDR && a <= CTRL_HI;
   endfunction

   function automatic bit in_flag(int a);
      return a >= FLAG_LO && a <= FLAG_HI;
   endfunction

   function automatic logic [7:0] mfg_value(int a);
      return (a == CAUSE_ADDR) ? CODE_POR : 8'h00;
   endfunction

endpackage

// File: rtl/regdef_walker.sv
module regdef_walker
   import regdef_pkg::*;
#(
   parameter int COUNT = BACKED_N
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   output logic                     busy,
   output logic [$clog2(COUNT)-1:0] idx,
   output logic                     last,
   output logic                     done
);
   localparam int IW = $clog2(COUNT);
   localparam logic [IW-1:0] IDX_END = IW'(COUNT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy) begin
            if (idx == IDX_END) begin
               busy <= 1'b0;
               idx  <= '0;
               done <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign last = busy && (idx == IDX_END);

   assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_ends_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: rtl/regdef_src_arb.sv
module regdef_src_arb
   import regdef_pkg::*;
#(
   parameter int AW      = 8,
   parameter bit SYNC_IN = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 uvlo,
   input  logic                 en,
   input  logic                 busy,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [CMD_W-1:0]     wr_cmd,
   output logic                 hw_restart,
   output restart_cause_e       cause,
   output logic                 cmd_go,
   output logic [CMD_W-1:0]     cmd_bits,
   output logic                 start_walk
);
   logic uvlo_s, en_s, uvlo_q, en_q;

   generate
      if (SYNC_IN) begin : g_sync
         logic [1:0] uvlo_ff, en_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               uvlo_ff <= 2'b00;
               en_ff   <= 2'b11;
            end else begin
               uvlo_ff <= {uvlo_ff[0], uvlo};
               en_ff   <= {en_ff[0], en};
            end
         end
         assign uvlo_s = uvlo_ff[1];
         assign en_s   = en_ff[1];
      end else begin : g_direct
         assign uvlo_s = uvlo;
         assign en_s   = en;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uvlo_q <= 1'b0;
         en_q   <= 1'b1;
      end else begin
         uvlo_q <= uvlo_s;
         en_q   <= en_s;
      end
   end

   logic uvlo_rise, en_rise;
   assign uvlo_rise  = uvlo_s && !uvlo_q;
   assign en_rise    = en_s && !en_q;
   assign hw_restart = uvlo_rise || en_rise;
   assign cause      = uvlo_rise ? CAUSE_UVLO : (en_rise ? CAUSE_EN : CAUSE_NONE);
   assign cmd_go     = wr_en && (wr_addr == AW'(CMD_ADDR)) && !busy && !hw_restart;
   assign cmd_bits   = wr_cmd;
   assign start_walk = hw_restart || (cmd_go && (|wr_cmd[CMD_PROG:CMD_DEFAULT]));

endmodule

// File: rtl/regdef_regfile.sv
module regdef_regfile
   import regdef_pkg::*;
#(
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter bit RD_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_restart,
   input  restart_cause_e   cause,
   input  logic             busy,
   input  logic             walk_last,
   input  logic [AW-1:0]    walk_addr,
   input  logic [DW-1:0]    walk_data,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic             cmd_go,
   input  logic [CMD_W-1:0] cmd_bits,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data
);
   localparam int DEPTH = 2 ** AW;

   logic [DW-1:0]    mem [DEPTH];
   logic [CMD_W-1:0] cmd_q;
   logic             bus_ok;
   logic [DW-1:0]    rd_comb;

   function automatic bit writable(int a);
      return in_backed(a) || in_flag(a) || (in_ctrl(a) && a != CMD_ADDR);
   endfunction

   assign bus_ok = wr_en && writable(int'(wr_addr)) && !(busy && wr_addr == walk_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= DW'(mfg_value(a));
         cmd_q <= '0;
      end else if (hw_restart) begin
         for (int a = CMD_ADDR; a <= FLAG_HI; a++)
            if (in_ctrl(a) || in_flag(a)) mem[AW'(a)] <= DW'(mfg_value(a));
         mem[AW'(CAUSE_ADDR)] <= DW'((cause == CAUSE_UVLO) ? CODE_UVLO : CODE_EN);
         cmd_q <= '0;
      end else begin
         if (busy) mem[walk_addr] <= walk_data;
         if (bus_ok) mem[wr_addr] <= wr_data;
         if (cmd_go && cmd_bits[CMD_DEFAULT])
            for (int a = CMD_ADDR + 1; a <= CTRL_HI; a++) mem[AW'(a)] <= DW'(mfg_value(a));
         if (cmd_go && cmd_bits[CMD_SOFT])
            mem[AW'(SOFT_ADDR)] <= DW'(mfg_value(SOFT_ADDR));
         if (cmd_go)
            cmd_q <= cmd_bits;
         else if (walk_last || !busy)
            cmd_q <= '0;
      end
   end

   always_comb begin
      if (rd_addr == AW'(CMD_ADDR))
         rd_comb = DW'(cmd_q);
      else if (writable(int'(rd_addr)))
         rd_comb = mem[rd_addr];
      else
         rd_comb = '0;
   end

   generate
      if (RD_REG) begin : g_rd_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= rd_comb;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_comb;
      end
   endgenerate

   assert_soft_clears_93_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && cmd_bits[CMD_SOFT]) |=> (mem[AW'(SOFT_ADDR)] == '0));
   assert_cmd_clear_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_last && !hw_restart) |=> (cmd_q == '0));
   assert_restart_drops_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hw_restart |=> (cmd_q == '0));

endmodule

// File: rtl/regdef_ctrl.sv
module regdef_ctrl
   import regdef_pkg::*;
#(
   parameter int AW      = 8,
   parameter int DW      = 8,
   parameter bit RD_REG  = 1'b0,
   parameter bit SYNC_IN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          uvlo,
   input  logic          en,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] eep_addr,
   input  logic [DW-1:0] eep_data,
   output logic          busy,
   output logic          load_done,
   output logic          failsafe,
   output logic          prog_mode
);
   localparam int IW = $clog2(BACKED_N);

   generate
      if (AW < 8) begin : g_bad_aw
         $error("regdef_ctrl: AW must cover address AFh");
      end
      if (DW < 8) begin : g_bad_dw
         $error("regdef_ctrl: DW must hold a full byte");
      end
   endgenerate

   logic                 hw_restart, cmd_go, start_walk, walk_last;
   restart_cause_e       cause;
   logic [CMD_W-1:0]     cmd_bits;
   logic [IW-1:0]        walk_idx;

   regdef_src_arb #(.AW(AW), .SYNC_IN(SYNC_IN)) u_arb (
      .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .en(en), .busy(busy),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_cmd(wr_data[CMD_W-1:0]),
      .hw_restart(hw_restart), .cause(cause), .cmd_go(cmd_go),
      .cmd_bits(cmd_bits), .start_walk(start_walk)
   );

   regdef_walker #(.COUNT(BACKED_N)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start_walk), .busy(busy),
      .idx(walk_idx), .last(walk_last), .done(load_done)
   );

   always_comb eep_addr = AW'(span_addr(int'(walk_idx)));

   regdef_regfile #(.AW(AW), .DW(DW), .RD_REG(RD_REG)) u_rf (
      .clk(clk), .rst_n(rst_n), .hw_restart(hw_restart), .cause(cause),
      .busy(busy), .walk_last(walk_last), .walk_addr(eep_addr),
      .walk_data(eep_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmd_go(cmd_go), .cmd_bits(cmd_bits),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         failsafe  <= 1'b0;
         prog_mode <= 1'b0;
      end else if (hw_restart) begin
         failsafe  <= 1'b0;
         prog_mode <= 1'b0;
      end else if (cmd_go) begin
         if (cmd_bits[CMD_SAFE]) failsafe  <= 1'b1;
         if (cmd_bits[CMD_PROG]) prog_mode <= 1'b1;
      end
   end

   assert_restart_clears_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_restart |=> (!failsafe && !prog_mode && busy));
   assert_busy_holds_modes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hw_restart) |=> ($stable(failsafe) && $stable(prog_mode)));
   assert_safe_cmd_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_go && cmd_bits[CMD_SAFE]) |=> failsafe);

endmodule

// File: tb/regdef_ctrl_bench.sv
module regdef_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n, uvlo, en, wr_en;
   logic [7:0] wr_addr, wr_data, rd_addr, rd_data, eep_addr, eep_data;
   logic       busy, load_done, failsafe, prog_mode;
   int         seed = 0;
   int         total = 0, bad = 0;
   logic [7:0] expm [256];

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [7:0] img(logic [7:0] a, int s);
      return 8'((int'(a) * 13) + (s * 29) + 5);
   endfunction

   assign eep_data = img(eep_addr, seed);

   regdef_ctrl u_regdef_ctrl (
      .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .en(en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .eep_addr(eep_addr), .eep_data(eep_data), .busy(busy), .load_done(load_done),
      .failsafe(failsafe), .prog_mode(prog_mode)
   );

   function automatic bit bk(int a);
      return (a <= 'h17) || (a >= 'h20 && a <= 'h37) || (a >= 'h40 && a <= 'h44) ||
             (a >= 'h50 && a <= 'h67) || (a >= 'h70 && a <= 'h87);
   endfunction
   function automatic bit ct(int a); return a >= 'h90 && a <= 'h98; endfunction
   function automatic bit fl(int a); return a >= 'hA0 && a <= 'hAF; endfunction

   task automatic check(string tag, int act, int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic mwr(int a, int d);
      wr(a, d);
      if (bk(a) || fl(a) || (ct(a) && a != 'h90)) expm[a] = 8'(d);
   endtask

   task automatic rd(int a, output int v);
      rd_addr = 8'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!load_done && n < 2000) begin
         tick();
         n++;
      end
   endtask

   task automatic reload_model();
      for (int a = 0; a < 256; a++) if (bk(a)) expm[a] = img(8'(a), seed);
   endtask

   task automatic restart_model(int code);
      for (int a = 'h90; a <= 'hAF; a++) if (ct(a) || fl(a)) expm[a] = 8'h00;
      expm['hA0] = 8'(code);
   endtask

   task automatic sweep(string tag);
      int v;
      for (int a = 0; a < 256; a++) begin
         rd(a, v);
         check($sformatf("%s addr=%0h", tag, a), v, int'(expm[a]));
      end
   endtask

   task automatic fill_ctrl(int base);
      for (int a = 'h91; a <= 'h98; a++) mwr(a, base + a);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, v;
      rst_n = 1'b0; uvlo = 1'b0; en = 1'b1; wr_en = 1'b0;
      wr_addr = '0; wr_data = '0; rd_addr = '0;
      for (int a = 0; a < 256; a++) expm[a] = 8'h00;
      expm['hA0] = 8'h01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 busy after reset", busy, 1);
      check("R2 failsafe after reset", failsafe, 0);
      check("R2 prog_mode after reset", prog_mode, 0);
      wait_done(n);
      check("R1 walk length", n, 101);
      tick();
      check("R1 done is one cycle", load_done, 0);
      check("R1 busy low after walk", busy, 0);
      reload_model();
      sweep("R2 reset image");

      // R12: bus access to each group and to unmapped addresses
      fill_ctrl('h20);
      for (int a = 'hA1; a <= 'hAF; a++) mwr(a, a ^ 'h3C);
      mwr('h05, 'hEE);
      mwr('h18, 'h77);
      mwr('h99, 'h66);
      mwr('h88, 'h55);
      sweep("R12 bus writes");

      // R3 reload, with R11 ignored command during the walk
      seed = 1;
      wr('h90, 'h02);
      check("R3 busy after reload cmd", busy, 1);
      rd('h90, v);
      check("R8 pending bits read back", v, 'h02);
      wr('h90, 'h14);
      wait_done(n);
      rd('h90, v);
      check("R8 bits clear at done", v, 0);
      check("R11 failsafe unchanged", failsafe, 0);
      reload_model();
      sweep("R3 reload keeps ctrl and flags");

      // R4 defaults command
      seed = 2;
      wr('h90, 'h01);
      wait_done(n);
      check("R4 walk length", n, 101);
      for (int a = 'h91; a <= 'h98; a++) expm[a] = 8'h00;
      reload_model();
      sweep("R4 defaults");

      // R7 soft reset
      fill_ctrl('h40);
      wr('h90, 'h10);
      check("R7 no walk", busy, 0);
      rd('h90, v);
      check("R8 soft bit visible", v, 'h10);
      tick();
      rd('h90, v);
      check("R8 soft bit cleared", v, 0);
      expm['h93] = 8'h00;
      sweep("R7 soft reset only 93h");

      // R5 fail-safe
      seed = 3;
      wr('h90, 'h04);
      check("R5 failsafe set", failsafe, 1);
      wait_done(n);
      reload_model();
      sweep("R5 failsafe keeps ctrl and flags");
      check("R5 failsafe held", failsafe, 1);

      // R6 program mode
      seed = 4;
      wr('h90, 'h08);
      check("R6 prog_mode set", prog_mode, 1);
      wait_done(n);
      reload_model();
      sweep("R6 program mode keeps ctrl and flags");

      // R9 undervoltage restart
      seed = 5;
      uvlo = 1'b1;
      tick();
      check("R9 uvlo clears failsafe", failsafe, 0);
      check("R9 uvlo clears prog_mode", prog_mode, 0);
      check("R9 uvlo restarts walk", busy, 1);
      wait_done(n);
      restart_model('h02);
      reload_model();
      sweep("R9 uvlo restart");
      uvlo = 1'b0;
      tick();
      check("R9 uvlo fall no action", busy, 0);

      // R9 enable restart
      mwr('h95, 'hAB);
      mwr('hA3, 'h5C);
      en = 1'b0;
      tick();
      check("R9 en fall no action", busy, 0);
      seed = 6;
      en = 1'b1;
      tick();
      check("R9 en rise restarts", busy, 1);
      wait_done(n);
      restart_model('h04);
      reload_model();
      sweep("R9 en restart");

      // R9 both together: undervoltage wins the cause code
      en = 1'b0;
      tick();
      mwr('h96, 'h11);
      seed = 7;
      en = 1'b1; uvlo = 1'b1;
      tick();
      wait_done(n);
      restart_model('h02);
      reload_model();
      sweep("R9 both rise");
      uvlo = 1'b0;
      tick();

      // R10 command write in the restart cycle is dropped
      mwr('h97, 'h2D);
      seed = 8;
      uvlo = 1'b1;
      wr('h90, 'h04);
      check("R10 failsafe not set", failsafe, 0);
      rd('h90, v);
      check("R10 command dropped", v, 0);
      wait_done(n);
      restart_model('h02);
      reload_model();
      sweep("R10 restart wins");
      uvlo = 1'b0;
      tick();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule